// File: doc/BRIEF.md
# Flash Controller Interrupt Status Unit

This block keeps the interrupt and error state of a flash controller. It owns a 16-bit interrupt status word, a 16-bit controller error word and two configuration registers. It receives register writes from the host side and single-cycle event pulses from the operation engine. It drives a level interrupt pin whose polarity is set in software, and a ready pin.

The block also gates command writes. A new command is passed on to the engine only when the master interrupt flag is clear. Software therefore has to acknowledge the previous result before it can issue another operation.

Software clears status bits by writing a word that is ANDed into the status: a 0 bit clears that flag and a 1 bit leaves it unchanged. If such a write leaves the master flag clear, the four error flags are cleared with it. An event that arrives in the same cycle as a clear always takes effect.

Top module: `flash_irq_status`

## Requirements
- R1: Synchronous reset values:
  - interrupt status is 0x8080 when `cold_sel`=1 and 0x8010 when `cold_sel`=0;
  - configuration-1 reads 0x40C0;
  - configuration-2, controller status and `cmd_code` are 0;
  - `rdy` is 1 and `cmd_go` is 0.
- R2: A pulse on `ev_load`, `ev_prog` or `ev_erase` sets interrupt bit 15 together with bit 7, bit 6 or bit 5 respectively, one cycle later.
- R3: `ev_cmd_err` sets interrupt bit 15 and controller bit 10. `ev_op_err` sets controller bit 10 plus a class bit chosen by `op_class`: 0 (load) sets bit 13, 1 (program) sets bit 12, 2 (erase) sets bit 11, and 3 sets no class bit.
- R4: A write with `wr_sel`=0 (interrupt register) replaces the status with status AND `wr_data`.
- R5: If the AND result of an interrupt write has bit 15 clear, controller bits 10..13 are cleared. If bit 15 stays set, those bits are kept.
- R6: `irq` always equals interrupt bit 15 XOR NOT configuration-1 bit 6.
- R7: A write with `wr_sel`=3 (command) while interrupt bit 15 is set is ignored: `cmd_go` stays 0 and `cmd_code` is unchanged. When bit 15 is clear, the write pulses `cmd_go` for one cycle and loads `cmd_code`.
- R8: A write with `wr_sel`=1 stores configuration-1 and sets `rdy` to its bit 7. `cfg1_rd` returns that value with bits 4..0 forced to 0. A write with `wr_sel`=2 stores configuration-2, which reads back whole on `cfg2_rd`.
- R9: `ev_reset` restores the warm values: interrupt 0x8010, configuration-1 0x40C0, configuration-2 0, controller status 0, `cmd_code` 0 and `rdy` 1. It overrides any write or event in the same cycle.
- R10: When an event and an interrupt-register clear land in the same cycle, the bits the event sets survive. An error event in the same cycle as a master clear leaves its error bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cold_sel | input | 1 | Selects the cold (1) or warm (0) interrupt reset value |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target register: 0 interrupt, 1 configuration-1, 2 configuration-2, 3 command |
| wr_data | input | 16 | Write data |
| ev_load | input | 1 | Load completed |
| ev_prog | input | 1 | Program completed |
| ev_erase | input | 1 | Erase completed |
| ev_reset | input | 1 | Engine reset completed (warm reset of this block) |
| ev_cmd_err | input | 1 | Unknown command |
| ev_op_err | input | 1 | Operation failed |
| op_class | input | 2 | Class of the failed operation |
| int_status | output | 16 | Interrupt status word |
| ctrl_status | output | 16 | Controller error word |
| cfg1_rd | output | 16 | Configuration-1 read value (bits 4..0 masked) |
| cfg2_rd | output | 16 | Configuration-2 value |
| cmd_code | output | 16 | Last accepted command |
| cmd_go | output | 1 | One-cycle pulse for an accepted command |
| irq | output | 1 | Interrupt pin level |
| rdy | output | 1 | Ready pin level |

## Verification
Two functions can act in the same cycle: an operation-engine event that sets flags, and a software write that clears them by AND. The bench raises `ev_load` in the same cycle as an all-zero interrupt write. It then raises `ev_cmd_err` in the same cycle as a master-clearing write while error bits are held. In both cases it expects the event's bits to be present on the next cycle and every other cleared bit to be gone. A third case pairs `ev_reset` with a command write and expects the reset to win.

// File: rtl/fisu_pkg.sv
package fisu_pkg;
  localparam int unsigned REG_W = 16;

  typedef enum logic [1:0] {
    SEL_INT  = 2'd0,
    SEL_CFG1 = 2'd1,
    SEL_CFG2 = 2'd2,
    SEL_CMD  = 2'd3
  } reg_sel_e;

  localparam int unsigned INT_MASTER = 15;

  // completion sources: index 0 load, 1 program, 2 erase
  localparam int unsigned NUM_DONE = 3;
  localparam int unsigned DONE_POS [NUM_DONE] = '{7, 6, 5};

  localparam int unsigned ERR_CMD = 10;
  // error class bits indexed by op_class: load, program, erase
  localparam int unsigned NUM_ERR_CLASS = 3;
  localparam int unsigned ERR_POS [NUM_ERR_CLASS] = '{13, 12, 11};
  localparam int unsigned ERR_LO = 10;
  localparam int unsigned ERR_HI = 13;

  localparam int unsigned CFG_POL_BIT = 6;
  localparam int unsigned CFG_RDY_BIT = 7;
endpackage

// File: rtl/fisu_intstat.sv
module fisu_intstat
  import fisu_pkg::*;
#(
  parameter int unsigned DW = REG_W,
  parameter logic [DW-1:0] COLD_VAL = 16'h8080,
  parameter logic [DW-1:0] WARM_VAL = 16'h8010
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cold_sel,
  input  logic          ev_reset,
  input  logic          wr_int,
  input  logic [DW-1:0] wr_data,
  input  logic          ev_load,
  input  logic          ev_prog,
  input  logic          ev_erase,
  input  logic          ev_cmd_err,
  input  logic          ev_op_err,
  input  logic [1:0]    op_class,
  output logic [DW-1:0] int_q,
  output logic [DW-1:0] err_q
);
  localparam logic [DW-1:0] MASTER_M = DW'(1) << INT_MASTER;
  localparam logic [DW-1:0] ERR_FIELD =
    ((DW'(1) << (ERR_HI + 1)) - DW'(1)) & ~((DW'(1) << ERR_LO) - DW'(1));

  logic [NUM_DONE-1:0] done_ev;
  logic [DW-1:0]       done_mask [NUM_DONE];
  logic [DW-1:0]       class_mask [NUM_ERR_CLASS];
  logic [DW-1:0]       done_set, err_set, int_and, int_d, err_d;
  logic                wipe;

  assign done_ev = {ev_erase, ev_prog, ev_load};

  for (genvar g = 0; g < NUM_DONE; g++) begin : g_done
    assign done_mask[g] = done_ev[g] ? (MASTER_M | (DW'(1) << DONE_POS[g])) : '0;
  end

  for (genvar c = 0; c < NUM_ERR_CLASS; c++) begin : g_cls
    assign class_mask[c] = (ev_op_err && (op_class == 2'(c))) ? (DW'(1) << ERR_POS[c]) : '0;
  end

  always_comb begin
    done_set = ev_cmd_err ? MASTER_M : '0;
    for (int i = 0; i < NUM_DONE; i++) done_set = done_set | done_mask[i];
    err_set = (ev_cmd_err || ev_op_err) ? (DW'(1) << ERR_CMD) : '0;
    for (int i = 0; i < NUM_ERR_CLASS; i++) err_set = err_set | class_mask[i];
  end

  assign int_and = wr_int ? (int_q & wr_data) : int_q;
  assign wipe    = wr_int && !int_and[INT_MASTER];
  // events are ORed after the clear so they are never lost
  assign int_d   = int_and | done_set;
  assign err_d   = (wipe ? (err_q & ~ERR_FIELD) : err_q) | err_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q <= cold_sel ? COLD_VAL : WARM_VAL;
      err_q <= '0;
    end else if (ev_reset) begin
      int_q <= WARM_VAL;
      err_q <= '0;
    end else begin
      int_q <= int_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/fisu_cfg.sv
module fisu_cfg
  import fisu_pkg::*;
#(
  parameter int unsigned DW = REG_W,
  parameter logic [DW-1:0] CFG1_RST = 16'h40C0,
  parameter int unsigned RD_MASK_BITS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_reset,
  input  logic          wr_cfg1,
  input  logic          wr_cfg2,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] cfg1_rd,
  output logic [DW-1:0] cfg2_q,
  output logic          pol_bit,
  output logic          rdy_q
);
  localparam logic [DW-1:0] RD_MASK = ~((DW'(1) << RD_MASK_BITS) - DW'(1));

  logic [DW-1:0] cfg1_q;

  always_ff @(posedge clk) begin
    if (rst || ev_reset) begin
      cfg1_q <= CFG1_RST;
      cfg2_q <= '0;
      rdy_q  <= 1'b1;
    end else begin
      if (wr_cfg1) begin
        cfg1_q <= wr_data;
        rdy_q  <= wr_data[CFG_RDY_BIT];
      end
      if (wr_cfg2) cfg2_q <= wr_data;
    end
  end

  assign cfg1_rd = cfg1_q & RD_MASK;
  assign pol_bit = cfg1_q[CFG_POL_BIT];
endmodule

// File: rtl/fisu_cmd_gate.sv
module fisu_cmd_gate
  import fisu_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_reset,
  input  logic          wr_cmd,
  input  logic          busy_flag,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] cmd_q,
  output logic          go_q
);
  logic take;
  assign take = wr_cmd && !busy_flag;

  always_ff @(posedge clk) begin
    if (rst || ev_reset) begin
      cmd_q <= '0;
      go_q  <= 1'b0;
    end else begin
      go_q <= take;
      if (take) cmd_q <= wr_data;
    end
  end
endmodule

// File: rtl/flash_irq_status.sv
module flash_irq_status
  import fisu_pkg::*;
#(
  parameter int unsigned DW = REG_W,
  parameter logic [DW-1:0] COLD_INT = 16'h8080,
  parameter logic [DW-1:0] WARM_INT = 16'h8010,
  parameter logic [DW-1:0] CFG1_RST = 16'h40C0,
  parameter int unsigned CFG1_RD_MASK_BITS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cold_sel,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          ev_load,
  input  logic          ev_prog,
  input  logic          ev_erase,
  input  logic          ev_reset,
  input  logic          ev_cmd_err,
  input  logic          ev_op_err,
  input  logic [1:0]    op_class,
  output logic [DW-1:0] int_status,
  output logic [DW-1:0] ctrl_status,
  output logic [DW-1:0] cfg1_rd,
  output logic [DW-1:0] cfg2_rd,
  output logic [DW-1:0] cmd_code,
  output logic          cmd_go,
  output logic          irq,
  output logic          rdy
);
  logic wr_int, wr_cfg1, wr_cfg2, wr_cmd, pol_bit;

  assign wr_int  = wr_en && (reg_sel_e'(wr_sel) == SEL_INT);
  assign wr_cfg1 = wr_en && (reg_sel_e'(wr_sel) == SEL_CFG1);
  assign wr_cfg2 = wr_en && (reg_sel_e'(wr_sel) == SEL_CFG2);
  assign wr_cmd  = wr_en && (reg_sel_e'(wr_sel) == SEL_CMD);

  fisu_intstat #(.DW(DW), .COLD_VAL(COLD_INT), .WARM_VAL(WARM_INT)) u_stat (
    .clk(clk), .rst(rst), .cold_sel(cold_sel), .ev_reset(ev_reset),
    .wr_int(wr_int), .wr_data(wr_data),
    .ev_load(ev_load), .ev_prog(ev_prog), .ev_erase(ev_erase),
    .ev_cmd_err(ev_cmd_err), .ev_op_err(ev_op_err), .op_class(op_class),
    .int_q(int_status), .err_q(ctrl_status)
  );

  fisu_cfg #(.DW(DW), .CFG1_RST(CFG1_RST), .RD_MASK_BITS(CFG1_RD_MASK_BITS)) u_cfg (
    .clk(clk), .rst(rst), .ev_reset(ev_reset),
    .wr_cfg1(wr_cfg1), .wr_cfg2(wr_cfg2), .wr_data(wr_data),
    .cfg1_rd(cfg1_rd), .cfg2_q(cfg2_rd), .pol_bit(pol_bit), .rdy_q(rdy)
  );

  fisu_cmd_gate #(.DW(DW)) u_cmd (
    .clk(clk), .rst(rst), .ev_reset(ev_reset),
    .wr_cmd(wr_cmd), .busy_flag(int_status[INT_MASTER]), .wr_data(wr_data),
    .cmd_q(cmd_code), .go_q(cmd_go)
  );

  // pin level from two flops; polarity bit 1 means active-high
  assign irq = int_status[INT_MASTER] ^ ~pol_bit;
endmodule

// File: rtl/fisu_checker.sv
module fisu_checker (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [15:0] wr_data,
  input logic        ev_load,
  input logic        ev_prog,
  input logic        ev_erase,
  input logic        ev_reset,
  input logic        ev_cmd_err,
  input logic        ev_op_err,
  input logic [15:0] int_status,
  input logic [15:0] ctrl_status,
  input logic [15:0] cfg1_rd,
  input logic [15:0] cmd_code,
  input logic        cmd_go,
  input logic        irq,
  input logic        rdy
);
  logic any_ev;
  assign any_ev = ev_load | ev_prog | ev_erase | ev_reset | ev_cmd_err | ev_op_err;

  AST_IRQ_POLARITY: assert property (@(posedge clk) disable iff (rst)
    irq == (int_status[15] ^ ~cfg1_rd[6])); // R6

  AST_CMD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3 && int_status[15]) |=> (!cmd_go && $stable(cmd_code))); // R7

  AST_CMD_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3 && !int_status[15] && !ev_reset)
      |=> (cmd_go && cmd_code == $past(wr_data))); // R7

  AST_LOAD_SETS: assert property (@(posedge clk) disable iff (rst)
    (ev_load && !ev_reset) |=> (int_status[15] && int_status[7])); // R2

  AST_AND_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0 && !any_ev)
      |=> int_status == ($past(int_status) & $past(wr_data))); // R4

  AST_ERR_WIPE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd0 && !(int_status[15] && wr_data[15]) && !any_ev)
      |=> ctrl_status[13:10] == 4'h0); // R5

  AST_RDY_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd1 && !ev_reset) |=> rdy == $past(wr_data[7])); // R8

  AST_WARM_RESET: assert property (@(posedge clk) disable iff (rst)
    ev_reset |=> (int_status == 16'h8010 && ctrl_status == 16'h0 && rdy)); // R9
endmodule

bind flash_irq_status fisu_checker u_chk (.*);

// File: tb/sim_flash_irq_status.sv
module sim_flash_irq_status;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cold_sel = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic        ev_load = 0, ev_prog = 0, ev_erase = 0, ev_reset = 0;
  logic        ev_cmd_err = 0, ev_op_err = 0;
  logic [1:0]  op_class = 2'd0;
  logic [15:0] int_status, ctrl_status, cfg1_rd, cfg2_rd, cmd_code;
  logic        cmd_go, irq, rdy;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flash_irq_status u0 (
    .clk(clk), .rst(rst), .cold_sel(cold_sel), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ev_load(ev_load), .ev_prog(ev_prog), .ev_erase(ev_erase),
    .ev_reset(ev_reset), .ev_cmd_err(ev_cmd_err), .ev_op_err(ev_op_err),
    .op_class(op_class), .int_status(int_status), .ctrl_status(ctrl_status),
    .cfg1_rd(cfg1_rd), .cfg2_rd(cfg2_rd), .cmd_code(cmd_code), .cmd_go(cmd_go),
    .irq(irq), .rdy(rdy)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%04h exp=0x%04h", tag, got, exp);
    end
  endtask

  task automatic clear_inputs();
    wr_en = 0; ev_load = 0; ev_prog = 0; ev_erase = 0; ev_reset = 0;
    ev_cmd_err = 0; ev_op_err = 0;
  endtask

  task automatic step();
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic do_reset(input logic cold);
    @(negedge clk);
    rst = 1; cold_sel = cold;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    step();
  endtask

  task automatic t_cold_reset();
    do_reset(1'b1);
    chk("R1 cold int", int_status, 16'h8080);
    chk("R1 cfg1", cfg1_rd, 16'h40C0);
    chk("R1 cfg2", cfg2_rd, 16'h0000);
    chk("R1 ctrl", ctrl_status, 16'h0000);
    chk("R1 cmd", cmd_code, 16'h0000);
    chk("R1 rdy/go", {14'd0, rdy, cmd_go}, 16'h0002);
  endtask

  task automatic t_warm_reset();
    do_reset(1'b0);
    chk("R1 warm int", int_status, 16'h8010);
  endtask

  task automatic t_done_events();
    do_reset(1'b1);
    wr(2'd0, 16'h0000);
    chk("R4 clear all", int_status, 16'h0000);
    ev_load = 1; step();
    chk("R2 load", int_status, 16'h8080);
    wr(2'd0, 16'h0000);
    ev_prog = 1; step();
    chk("R2 prog", int_status, 16'h8040);
    wr(2'd0, 16'h0000);
    ev_erase = 1; step();
    chk("R2 erase", int_status, 16'h8020);
  endtask

  task automatic t_errors();
    do_reset(1'b1);
    wr(2'd0, 16'h0000);
    ev_op_err = 1; op_class = 2'd2; step();
    chk("R3 erase err", ctrl_status, 16'h0C00);
    ev_op_err = 1; op_class = 2'd0; step();
    chk("R3 load err", ctrl_status, 16'h2C00);
    ev_op_err = 1; op_class = 2'd1; step();
    chk("R3 prog err", ctrl_status, 16'h3C00);
    chk("R3 op err no master", int_status, 16'h0000);
    wr(2'd0, 16'h0000);
    ev_cmd_err = 1; step();
    chk("R3 cmd err int", int_status, 16'h8000);
    chk("R3 cmd err ctrl", ctrl_status, 16'h0400);
  endtask

  task automatic t_master_wipe();
    do_reset(1'b1);
    ev_op_err = 1; op_class = 2'd1; step();
    wr(2'd0, 16'h8000);
    chk("R4 keep master", int_status, 16'h8000);
    chk("R5 errors kept", ctrl_status, 16'h1400);
    wr(2'd0, 16'h7FFF);
    chk("R4 and", int_status, 16'h0000);
    chk("R5 errors wiped", ctrl_status, 16'h0000);
  endtask

  task automatic t_polarity();
    do_reset(1'b1);
    chk("R6 default high", {15'd0, irq}, 16'h0001);
    wr(2'd1, 16'h0000);
    chk("R6 inverted", {15'd0, irq}, 16'h0000);
    chk("R8 rdy low", {15'd0, rdy}, 16'h0000);
    wr(2'd1, 16'h00FF);
    chk("R8 cfg1 mask", cfg1_rd, 16'h00E0);
    chk("R8 rdy high", {15'd0, rdy}, 16'h0001);
    wr(2'd0, 16'h0000);
    chk("R6 cleared", {15'd0, irq}, 16'h0000);
    wr(2'd1, 16'h0080);
    chk("R6 low-active idle", {15'd0, irq}, 16'h0001);
    wr(2'd2, 16'hA5C3);
    chk("R8 cfg2", cfg2_rd, 16'hA5C3);
  endtask

  task automatic t_cmd_gate();
    do_reset(1'b1);
    wr(2'd3, 16'h0094);
    chk("R7 blocked go", {15'd0, cmd_go}, 16'h0000);
    chk("R7 blocked code", cmd_code, 16'h0000);
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0094);
    chk("R7 accepted go", {15'd0, cmd_go}, 16'h0001);
    chk("R7 accepted code", cmd_code, 16'h0094);
    step();
    chk("R7 go one cycle", {15'd0, cmd_go}, 16'h0000);
  endtask

  task automatic t_ev_reset();
    do_reset(1'b1);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h1234);
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0080);
    ev_op_err = 1; step();
    ev_reset = 1; wr_en = 1; wr_sel = 2'd3; wr_data = 16'h00F3; step();
    chk("R9 int", int_status, 16'h8010);
    chk("R9 ctrl", ctrl_status, 16'h0000);
    chk("R9 cfg1", cfg1_rd, 16'h40C0);
    chk("R9 cfg2", cfg2_rd, 16'h0000);
    chk("R9 cmd", cmd_code, 16'h0000);
    chk("R9 rdy/go", {14'd0, rdy, cmd_go}, 16'h0002);
  endtask

  task automatic t_collision();
    do_reset(1'b1);
    wr_en = 1; wr_sel = 2'd0; wr_data = 16'h0000; ev_load = 1; step();
    chk("R10 load vs clear", int_status, 16'h8080);
    ev_op_err = 1; op_class = 2'd0; step();
    wr_en = 1; wr_sel = 2'd0; wr_data = 16'h0000; ev_cmd_err = 1; step();
    chk("R10 err vs wipe ctrl", ctrl_status, 16'h0400);
    chk("R10 err vs wipe int", int_status, 16'h8000);
  endtask

  initial begin
    t_cold_reset();
    t_warm_reset();
    t_done_events();
    t_errors();
    t_master_wipe();
    t_polarity();
    t_cmd_gate();
    t_ev_reset();
    t_collision();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog got=running exp=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule